// File: doc/BRIEF.md
# Circular Floating-Point Register Stack

This block holds the data registers of a floating-point unit as a circular stack. A small pointer names the current top register, and every operand is addressed relative to it: slot `i` of the stack is physical register `(top + i) mod DEPTH`. Loading a value moves the pointer down one place and stores the value there. Removing a value moves the pointer up one place. The pointer wraps at both ends. Each register carries a tag bit that marks it as holding data or as empty. The block reports two faults, each as a one-cycle pulse. An overflow pulse is raised when a load would land on a register that still holds data. An underflow pulse is raised when an empty slot is read or removed.

The surrounding arithmetic unit drives a command port. The port can push a value, pop, replace the top value (push and pop together), or write to any relative slot. Two independent read ports, each addressed by relative index, supply operands one cycle after the request. A pop returns its value on a read port that names slot 0 in the same cycle. Memory format conversion and the arithmetic itself are handled elsewhere.

Top module: `fpstk_core`

## Requirements
- R1: A synchronous active-high reset sets the top pointer to 0, marks every register empty and clears both fault outputs.
- R2: A push alone into an empty target first moves the top pointer to (top-1) mod DEPTH, then stores the input value there and marks that register valid. A later read of slot 0 returns the value.
- R3: A push whose target register (top-1) is still valid raises `ovf_o` for one cycle. The pointer and every register's contents and tag stay unchanged.
- R4: A pop alone of a valid slot 0 marks that register empty and moves the pointer to (top+1) mod DEPTH. A pop of an empty slot 0 raises `unf_o` and leaves the pointer unchanged.
- R5: A push at top 0 wraps the pointer to DEPTH-1 (7 by default), and a pop at top DEPTH-1 wraps it to 0.
- R6: Each read port returns the contents of physical register (top+idx) mod DEPTH one cycle after the cycle its request is presented. It uses the pointer and contents as they stood before that cycle's command. The two ports are independent.
- R7: A read request (enable high) on an empty slot raises `unf_o` in the following cycle.
- R8: Push and pop together replace the contents of slot 0 with the input value, and the pointer does not move. If slot 0 is empty, the command instead raises `unf_o` and changes nothing.
- R9: A write command alone stores the input value in slot `wr_idx_i`, marks it valid and leaves the pointer unchanged. A write is ignored whenever push or pop is also asserted.
- R10: The fault outputs are registered and last exactly one cycle per faulting cycle. They are low in the cycle after a command that does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push the input value (with `pop_i`: replace slot 0) |
| pop_i | input | 1 | Pop slot 0 |
| wr_i | input | 1 | Write the input value to relative slot `wr_idx_i` |
| wr_idx_i | input | AW (3) | Relative slot for the write command |
| din_i | input | WIDTH (80) | Value for push, replace or write |
| rda_en_i | input | 1 | Read port A request, checked for underflow |
| rda_idx_i | input | AW (3) | Relative slot for read port A |
| rdb_en_i | input | 1 | Read port B request, checked for underflow |
| rdb_idx_i | input | AW (3) | Relative slot for read port B |
| rda_data_o | output | WIDTH (80) | Read port A data, one cycle latency |
| rdb_data_o | output | WIDTH (80) | Read port B data, one cycle latency |
| top_o | output | AW (3) | Current top pointer |
| ovf_o | output | 1 | Overflow fault pulse |
| unf_o | output | 1 | Underflow fault pulse |

## Verification
The bench builds the block with its defaults: eight registers 80 bits wide, and a 3-bit pointer that wraps naturally at both ends. With depth eight, a short run fills the whole stack. That makes the overflow on the ninth push reachable, along with the full unwind through the 7-to-0 wrap and the underflow that follows. Each input value repeats a 16-bit marker five times across the 80 bits, so a corrupted or misrouted register shows at every read port.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PUSH,
    OP_POP,
    OP_REPLACE,
    OP_WRITE
  } stk_op_e;

  // Push and pop together mean replace; a write yields to either.
  function automatic stk_op_e decode_op(input logic push, input logic pop,
                                        input logic wr);
    if (push && pop)      return OP_REPLACE;
    else if (push)        return OP_PUSH;
    else if (pop)         return OP_POP;
    else if (wr)          return OP_WRITE;
    else                  return OP_NONE;
  endfunction

endpackage

// File: rtl/fpstk_bank.sv
// One write port, one registered read port; read returns the old contents.
module fpstk_bank #(
  parameter int WIDTH = 80,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NRD   = 2,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic          rd_en_i  [NRD],
  input  logic [AW-1:0] rd_idx_i [NRD],
  output logic [AW-1:0] rd_phys_o [NRD],
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] top_o,
  output logic          ovf_o,
  output logic          unf_o
);

  stk_op_e          op;
  logic [AW-1:0]    top_q, top_d;
  logic [DEPTH-1:0] tag_q, tag_d;
  logic             ovf_d, unf_cmd, unf_rd;
  logic [AW-1:0]    slot_dn, slot_up, slot_wr;

  assign slot_dn = top_q - 1'b1;
  assign slot_up = top_q + 1'b1;
  assign slot_wr = top_q + wr_idx_i;

  always_comb begin
    op      = decode_op(push_i, pop_i, wr_i);
    top_d   = top_q;
    tag_d   = tag_q;
    we_o    = 1'b0;
    waddr_o = top_q;
    ovf_d   = 1'b0;
    unf_cmd = 1'b0;
    unique case (op)
      OP_PUSH: begin
        if (tag_q[slot_dn]) begin
          ovf_d = 1'b1;
        end else begin
          we_o           = 1'b1;
          waddr_o        = slot_dn;
          top_d          = slot_dn;
          tag_d[slot_dn] = 1'b1;
        end
      end
      OP_POP: begin
        if (!tag_q[top_q]) begin
          unf_cmd = 1'b1;
        end else begin
          tag_d[top_q] = 1'b0;
          top_d        = slot_up;
        end
      end
      OP_REPLACE: begin
        if (!tag_q[top_q]) unf_cmd = 1'b1;
        else               we_o    = 1'b1;
      end
      OP_WRITE: begin
        we_o           = 1'b1;
        waddr_o        = slot_wr;
        tag_d[slot_wr] = 1'b1;
      end
      OP_NONE: ;
    endcase
  end

  always_comb begin
    unf_rd = 1'b0;
    for (int k = 0; k < NRD; k++) begin
      rd_phys_o[k] = top_q + rd_idx_i[k];
      if (rd_en_i[k] && !tag_q[top_q + rd_idx_i[k]]) unf_rd = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= '0;
      tag_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      top_q <= top_d;
      tag_q <= tag_d;
      ovf_o <= ovf_d;
      unf_o <= unf_cmd | unf_rd;
    end
  end

  assign top_o = top_q;

endmodule

// File: rtl/fpstk_core.sv
module fpstk_core #(
  parameter int WIDTH = 80,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    wr_idx_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             rda_en_i,
  input  logic [AW-1:0]    rda_idx_i,
  input  logic             rdb_en_i,
  input  logic [AW-1:0]    rdb_idx_i,
  output logic [WIDTH-1:0] rda_data_o,
  output logic [WIDTH-1:0] rdb_data_o,
  output logic [AW-1:0]    top_o,
  output logic             ovf_o,
  output logic             unf_o
);

  localparam int NRD = 2;

  logic             rd_en   [NRD];
  logic [AW-1:0]    rd_idx  [NRD];
  logic [AW-1:0]    rd_phys [NRD];
  logic [WIDTH-1:0] rd_data [NRD];
  logic             we;
  logic [AW-1:0]    waddr;

  assign rd_en[0]  = rda_en_i;
  assign rd_en[1]  = rdb_en_i;
  assign rd_idx[0] = rda_idx_i;
  assign rd_idx[1] = rdb_idx_i;

  fpstk_ctrl #(.DEPTH(DEPTH), .NRD(NRD), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .wr_i     (wr_i),
    .wr_idx_i (wr_idx_i),
    .rd_en_i  (rd_en),
    .rd_idx_i (rd_idx),
    .rd_phys_o(rd_phys),
    .we_o     (we),
    .waddr_o  (waddr),
    .top_o    (top_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
  );

  // One copy of the register file per read port keeps each copy 1W1R.
  for (genvar g = 0; g < NRD; g++) begin : g_bank
    fpstk_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk  (clk),
      .we   (we),
      .waddr(waddr),
      .wdata(din_i),
      .raddr(rd_phys[g]),
      .rdata(rd_data[g])
    );
  end

  assign rda_data_o = rd_data[0];
  assign rdb_data_o = rd_data[1];

endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] top_o,
  input logic          ovf_o,
  input logic          unf_o
);

  logic armed_q = 1'b0;
  logic rst_q   = 1'b0;
  logic past_ok;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) armed_q <= 1'b1;
  end

  assign past_ok = armed_q && !rst_q;

  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    (armed_q && rst_q) |-> (top_o == '0 && !ovf_o && !unf_o));

  // R2, R5
  p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(push_i && !pop_i) && !ovf_o)
      |-> top_o == AW'($past(top_o) - 1'b1));

  // R3
  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ovf_o) |-> (top_o == $past(top_o)));

  // R3, R10
  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ovf_o) |-> $past(push_i && !pop_i));

  // R4
  p_pop_step_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(pop_i && !push_i) && top_o != $past(top_o))
      |-> top_o == AW'($past(top_o) + 1'b1));

  // R8
  p_replace_still_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(push_i && pop_i)) |-> (top_o == $past(top_o)));

endmodule

bind fpstk_core fpstk_chk #(.AW(AW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .push_i(push_i),
  .pop_i (pop_i),
  .top_o (top_o),
  .ovf_o (ovf_o),
  .unf_o (unf_o)
);

// File: tb/sim_fpstk_core.sv
module sim_fpstk_core;

  localparam int CLK_P  = 10;
  localparam int WIDTH  = 80;
  localparam int DEPTH  = 8;
  localparam int AW     = 3;
  localparam int NV     = 31;
  localparam int WD_MAX = 5000;

  typedef struct packed {
    logic [3:0]  req;
    logic        push, pop, wr;
    logic [2:0]  widx;
    logic [15:0] d;
    logic        ae;
    logic [2:0]  ai;
    logic        be;
    logic [2:0]  bi;
    logic [2:0]  etop;
    logic        eovf, eunf;
    logic        cka;
    logic [15:0] ea;
    logic        ckb;
    logic [15:0] eb;
  } vec_t;

  // req  push pop wr widx data  ae ai be bi  top ovf unf  cka ea  ckb eb
  localparam vec_t TBL [NV] = '{
    '{4'd2, 1,0,0,3'd0,16'h1111, 0,3'd0,0,3'd0, 3'd7,0,0, 0,16'h0,    0,16'h0},    // R5 push wraps 0->7
    '{4'd2, 1,0,0,3'd0,16'h2222, 1,3'd0,0,3'd0, 3'd6,0,0, 1,16'h1111, 0,16'h0},    // R2
    '{4'd6, 0,0,0,3'd0,16'h0,    1,3'd0,1,3'd1, 3'd6,0,0, 1,16'h2222, 1,16'h1111}, // R6 two ports
    '{4'd9, 0,0,1,3'd1,16'h3333, 0,3'd0,1,3'd1, 3'd6,0,0, 0,16'h0,    1,16'h1111}, // R9 write, old data read
    '{4'd7, 0,0,0,3'd0,16'h0,    1,3'd2,1,3'd1, 3'd6,0,1, 0,16'h0,    1,16'h3333}, // R7 empty read
    '{4'd4, 0,1,0,3'd0,16'h0,    1,3'd0,0,3'd0, 3'd7,0,0, 1,16'h2222, 0,16'h0},    // R4 pop
    '{4'd8, 1,1,0,3'd0,16'h4444, 1,3'd0,0,3'd0, 3'd7,0,0, 1,16'h3333, 0,16'h0},    // R8 replace
    '{4'd8, 0,0,0,3'd0,16'h0,    1,3'd0,0,3'd0, 3'd7,0,0, 1,16'h4444, 0,16'h0},    // R8 replaced value
    '{4'd5, 0,1,0,3'd0,16'h0,    1,3'd0,0,3'd0, 3'd0,0,0, 1,16'h4444, 0,16'h0},    // R5 pop wraps 7->0
    '{4'd4, 0,1,0,3'd0,16'h0,    0,3'd0,0,3'd0, 3'd0,0,1, 0,16'h0,    0,16'h0},    // R4 pop empty
    '{4'd8, 1,1,0,3'd0,16'h7777, 0,3'd0,0,3'd0, 3'd0,0,1, 0,16'h0,    0,16'h0},    // R8 replace empty
    '{4'd2, 1,0,0,3'd0,16'h5000, 0,3'd0,0,3'd0, 3'd7,0,0, 0,16'h0,    0,16'h0},    // R10 pulse cleared
    '{4'd2, 1,0,0,3'd0,16'h5001, 0,3'd0,0,3'd0, 3'd6,0,0, 0,16'h0,    0,16'h0},
    '{4'd2, 1,0,0,3'd0,16'h5002, 0,3'd0,0,3'd0, 3'd5,0,0, 0,16'h0,    0,16'h0},
    '{4'd2, 1,0,0,3'd0,16'h5003, 0,3'd0,0,3'd0, 3'd4,0,0, 0,16'h0,    0,16'h0},
    '{4'd2, 1,0,0,3'd0,16'h5004, 0,3'd0,0,3'd0, 3'd3,0,0, 0,16'h0,    0,16'h0},
    '{4'd2, 1,0,0,3'd0,16'h5005, 0,3'd0,0,3'd0, 3'd2,0,0, 0,16'h0,    0,16'h0},
    '{4'd2, 1,0,0,3'd0,16'h5006, 0,3'd0,0,3'd0, 3'd1,0,0, 0,16'h0,    0,16'h0},
    '{4'd2, 1,0,0,3'd0,16'h5007, 0,3'd0,0,3'd0, 3'd0,0,0, 0,16'h0,    0,16'h0},
    '{4'd3, 1,0,0,3'd0,16'h5555, 1,3'd0,0,3'd0, 3'd0,1,0, 1,16'h5007, 0,16'h0},    // R3 overflow
    '{4'd3, 0,0,0,3'd0,16'h0,    1,3'd7,1,3'd0, 3'd0,0,0, 1,16'h5000, 1,16'h5007}, // R3 contents kept
    '{4'd9, 0,1,1,3'd2,16'h6666, 1,3'd0,0,3'd0, 3'd1,0,0, 1,16'h5007, 0,16'h0},    // R9 write ignored on pop
    '{4'd9, 0,0,0,3'd0,16'h0,    1,3'd1,1,3'd7, 3'd1,0,1, 1,16'h5005, 0,16'h0},    // R9 target unchanged
    '{4'd4, 0,1,0,3'd0,16'h0,    1,3'd0,0,3'd0, 3'd2,0,0, 1,16'h5006, 0,16'h0},
    '{4'd4, 0,1,0,3'd0,16'h0,    1,3'd0,0,3'd0, 3'd3,0,0, 1,16'h5005, 0,16'h0},
    '{4'd4, 0,1,0,3'd0,16'h0,    1,3'd0,0,3'd0, 3'd4,0,0, 1,16'h5004, 0,16'h0},
    '{4'd4, 0,1,0,3'd0,16'h0,    1,3'd0,0,3'd0, 3'd5,0,0, 1,16'h5003, 0,16'h0},
    '{4'd4, 0,1,0,3'd0,16'h0,    1,3'd0,0,3'd0, 3'd6,0,0, 1,16'h5002, 0,16'h0},
    '{4'd4, 0,1,0,3'd0,16'h0,    1,3'd0,0,3'd0, 3'd7,0,0, 1,16'h5001, 0,16'h0},
    '{4'd5, 0,1,0,3'd0,16'h0,    1,3'd0,0,3'd0, 3'd0,0,0, 1,16'h5000, 0,16'h0},    // R5 wrap
    '{4'd4, 0,1,0,3'd0,16'h0,    0,3'd0,0,3'd0, 3'd0,0,1, 0,16'h0,    0,16'h0}     // R4 empty after unwind
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             push_i = 1'b0, pop_i = 1'b0, wr_i = 1'b0;
  logic [AW-1:0]    wr_idx_i = '0;
  logic [WIDTH-1:0] din_i = '0;
  logic             rda_en_i = 1'b0, rdb_en_i = 1'b0;
  logic [AW-1:0]    rda_idx_i = '0, rdb_idx_i = '0;
  logic [WIDTH-1:0] rda_data_o, rdb_data_o;
  logic [AW-1:0]    top_o;
  logic             ovf_o, unf_o;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  fpstk_core #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    push_i = 0; pop_i = 0; wr_i = 0; wr_idx_i = '0; din_i = '0;
    rda_en_i = 0; rdb_en_i = 0; rda_idx_i = '0; rdb_idx_i = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_MAX) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WD_MAX);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "top after reset", WIDTH'(top_o), 0);
    check("R1", "ovf after reset", WIDTH'(ovf_o), 0);
    check("R1", "unf after reset", WIDTH'(unf_o), 0);
    rda_en_i = 1; rda_idx_i = 3'd3;
    @(negedge clk);
    check("R1", "tags empty after reset (read flags underflow)", WIDTH'(unf_o), 1);
    idle_inputs();
    @(negedge clk);
    check("R10", "underflow pulse cleared", WIDTH'(unf_o), 0);

    for (int v = 0; v < NV; v++) begin
      push_i    = TBL[v].push;
      pop_i     = TBL[v].pop;
      wr_i      = TBL[v].wr;
      wr_idx_i  = TBL[v].widx;
      din_i     = {5{TBL[v].d}};
      rda_en_i  = TBL[v].ae;
      rda_idx_i = TBL[v].ai;
      rdb_en_i  = TBL[v].be;
      rdb_idx_i = TBL[v].bi;
      @(negedge clk);
      check(req_name(TBL[v].req), $sformatf("vec %0d top", v), WIDTH'(top_o), WIDTH'(TBL[v].etop));
      check(req_name(TBL[v].req), $sformatf("vec %0d ovf", v), WIDTH'(ovf_o), WIDTH'(TBL[v].eovf));
      check(req_name(TBL[v].req), $sformatf("vec %0d unf", v), WIDTH'(unf_o), WIDTH'(TBL[v].eunf));
      if (TBL[v].cka)
        check(req_name(TBL[v].req), $sformatf("vec %0d port A", v), rda_data_o, {5{TBL[v].ea}});
      if (TBL[v].ckb)
        check(req_name(TBL[v].req), $sformatf("vec %0d port B", v), rdb_data_o, {5{TBL[v].eb}});
    end
    idle_inputs();

    // R1: reset in the middle of a run with data present
    push_i = 1; din_i = {5{16'hABCD}};
    @(negedge clk);
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "top after mid-run reset", WIDTH'(top_o), 0);
    rda_en_i = 1; rda_idx_i = 3'd7;
    @(negedge clk);
    check("R1", "register emptied by mid-run reset", WIDTH'(unf_o), 1);
    idle_inputs();
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule